// File: doc/BRIEF.md
# Second-Operand Shift and Constant Unit

This combinational unit forms the second source operand of a 32-bit data-processing datapath. A single control bit chooses between two interpretations of a 12-bit operand field. In constant form the field carries an 8-bit value and a 4-bit rotation code. The value is zero-extended and rotated right by twice the code, which gives even rotations from 0 to 30. In register form the field selects one of four shift kinds and a source for the shift amount. The supplied register value is then shifted by that amount.

The shift amount comes either from a 5-bit count inside the field or from the low byte of a second register value. The unit also produces a shifter carry. The ALU consumes it beside the shifted operand. The unit has no clock and no state, so its outputs follow its inputs within the same cycle.

Top module: `opnd2_shifter`

## Requirements
- R1: With `use_imm`=1, `operand_out` equals the zero-extended constant `op_field[7:0]` rotated right by 2*`op_field[11:8]` bit positions. For example, constant 0xFF with rotation code 4 yields 0xFF000000.
- R2: With `use_imm`=1 and rotation code 0, `operand_out` is the zero-extended constant and `carry_out` equals `carry_in`.
- R3: With `use_imm`=1 and a nonzero rotation code, `carry_out` equals `operand_out[31]`.
- R4: Shift kind 0 (logical left) moves `rm_val` up and fills with zeros. For amounts 1 to 32, `carry_out` is the last bit moved out, `rm_val[32-amount]`.
- R5: Shift kind 1 (logical right) moves `rm_val` down and fills with zeros. For amounts 1 to 32, `carry_out` is `rm_val[amount-1]`.
- R6: Shift kind 2 (arithmetic right) moves `rm_val` down and fills with copies of bit 31. For amounts 1 to 31, `carry_out` is `rm_val[amount-1]`.
- R7: Shift kind 3 (rotate right) wraps the low bits into the top. A right rotation by 32-n equals a left rotation by n. For any nonzero amount, `carry_out` equals `operand_out[31]`.
- R8: In register form the field layout is: bit 4 selects the amount source (0 = field count, 1 = register), bits 6:5 give the shift kind, and bits 11:7 give the 5-bit count. Bits 3:0 are ignored. With bit 4 set, only `rs_val[7:0]` is used and `rs_val[31:8]` has no effect.
- R9: In register form an amount of zero passes `rm_val` through unchanged, whatever the shift kind, and `carry_out` equals `carry_in`.
- R10: For logical shifts by 32 or more, `operand_out` is zero. The carry is `rm_val[0]` (left) or `rm_val[31]` (right) at exactly 32, and 0 above 32.
- R11: For an arithmetic right shift by 32 or more, every bit of `operand_out` and `carry_out` equal `rm_val[31]`.
- R12: For a rotate by 32 or more, the amount is taken modulo 32. A nonzero multiple of 32 leaves `rm_val` unchanged and sets `carry_out` to `rm_val[31]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_field | input | 12 | Operand field: constant and rotation code, or shift control |
| use_imm | input | 1 | 1 = rotated constant, 0 = shifted register |
| rm_val | input | 32 | Register value to be shifted |
| rs_val | input | 32 | Register whose low byte supplies a variable shift amount |
| carry_in | input | 1 | Current carry flag, passed on when nothing is shifted |
| operand_out | output | 32 | Second operand for the ALU |
| carry_out | output | 1 | Shifter carry |

## Verification
The bench builds the unit with its defaults: a 32-bit word, an 8-bit constant, a 4-bit rotation code and an 8-bit variable amount. The register amount can therefore reach 255. This exposes the saturation of the logical and arithmetic shifts at and beyond the word width, and the modulo-32 wrap of the rotate at 32, 64 and higher multiples. Every one of the sixteen rotation codes can appear in constant form, so the full set of even rotations is reached.

// File: rtl/opnd2_pkg.sv
package opnd2_pkg;

    localparam int OP_AMT_W = 8;

    typedef enum logic [1:0] {
        SHK_LSL = 2'd0,
        SHK_LSR = 2'd1,
        SHK_ASR = 2'd2,
        SHK_ROR = 2'd3
    } shift_kind_e;

    typedef struct packed {
        shift_kind_e            kind;
        logic [OP_AMT_W-1:0]    amount;
    } shift_req_t;

endpackage

// File: rtl/opnd2_imm_rotator.sv
module opnd2_imm_rotator #(
    parameter int XLEN   = 32,
    parameter int CONSTW = 8,
    parameter int ROTW   = 4
) (
    input  logic [CONSTW-1:0] konst,
    input  logic [ROTW-1:0]   rot_code,
    input  logic              carry_in,
    output logic [XLEN-1:0]   result,
    output logic              carry_out
);
    localparam int SHW = ROTW + 1;

    logic [SHW-1:0]    rot_amt;
    logic [XLEN-1:0]   wide_k;
    logic [2*XLEN-1:0] dbl;

    always_comb begin
        rot_amt   = {rot_code, 1'b0};
        wide_k    = {{(XLEN-CONSTW){1'b0}}, konst};
        dbl       = {wide_k, wide_k} >> rot_amt;
        result    = dbl[XLEN-1:0];
        carry_out = (rot_code == '0) ? carry_in : dbl[XLEN-1];
    end
endmodule

// File: rtl/opnd2_shift_core.sv
module opnd2_shift_core
    import opnd2_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  shift_req_t        req,
    input  logic [XLEN-1:0]   value,
    input  logic              carry_in,
    output logic [XLEN-1:0]   result,
    output logic              carry_out
);
    localparam int MODW = $clog2(XLEN);

    logic [XLEN:0]        lsl_t;
    logic [XLEN:0]        lsr_t;
    logic signed [XLEN:0] asr_t;
    logic [2*XLEN-1:0]    ror_t;

    always_comb begin
        lsl_t = {1'b0, value} << req.amount;
        lsr_t = {value, 1'b0} >> req.amount;
        asr_t = $signed({value, 1'b0}) >>> req.amount;
        ror_t = {value, value} >> req.amount[MODW-1:0];

        if (req.amount == '0) begin
            result    = value;
            carry_out = carry_in;
        end else begin
            unique case (req.kind)
                SHK_LSL: begin
                    result    = lsl_t[XLEN-1:0];
                    carry_out = lsl_t[XLEN];
                end
                SHK_LSR: begin
                    result    = lsr_t[XLEN:1];
                    carry_out = lsr_t[0];
                end
                SHK_ASR: begin
                    result    = asr_t[XLEN:1];
                    carry_out = asr_t[0];
                end
                default: begin
                    result    = ror_t[XLEN-1:0];
                    carry_out = ror_t[XLEN-1];
                end
            endcase
        end
    end
endmodule

// File: rtl/opnd2_shifter.sv
module opnd2_shifter
    import opnd2_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int CONSTW = 8,
    parameter int ROTW   = 4
) (
    input  logic [CONSTW+ROTW-1:0] op_field,
    input  logic                   use_imm,
    input  logic [XLEN-1:0]        rm_val,
    input  logic [XLEN-1:0]        rs_val,
    input  logic                   carry_in,
    output logic [XLEN-1:0]        operand_out,
    output logic                   carry_out
);
    localparam int FIELDW   = CONSTW + ROTW;
    localparam int CNTW     = $clog2(XLEN);
    localparam int SRC_BIT  = 4;
    localparam int KIND_LO  = SRC_BIT + 1;
    localparam int CNT_LO   = KIND_LO + 2;

    shift_req_t        req_d;
    logic [XLEN-1:0]   imm_res, reg_res;
    logic              imm_c, reg_c;
    logic              unused_bits;

    assign unused_bits = ^{op_field[SRC_BIT-1:0], rs_val[XLEN-1:OP_AMT_W]};

    always_comb begin
        req_d.kind = shift_kind_e'(op_field[KIND_LO +: 2]);
        if (op_field[SRC_BIT])
            req_d.amount = rs_val[OP_AMT_W-1:0];
        else
            req_d.amount = {{(OP_AMT_W-CNTW){1'b0}}, op_field[CNT_LO +: CNTW]};
    end

    opnd2_imm_rotator #(.XLEN(XLEN), .CONSTW(CONSTW), .ROTW(ROTW)) u_imm (
        .konst     (op_field[CONSTW-1:0]),
        .rot_code  (op_field[FIELDW-1:CONSTW]),
        .carry_in  (carry_in),
        .result    (imm_res),
        .carry_out (imm_c)
    );

    opnd2_shift_core #(.XLEN(XLEN)) u_core (
        .req       (req_d),
        .value     (rm_val),
        .carry_in  (carry_in),
        .result    (reg_res),
        .carry_out (reg_c)
    );

    always_comb begin
        operand_out = use_imm ? imm_res : reg_res;
        carry_out   = use_imm ? imm_c   : reg_c;
    end
endmodule

// File: rtl/opnd2_shifter_chk.sv
module opnd2_shifter_chk #(
    parameter int XLEN   = 32,
    parameter int CONSTW = 8,
    parameter int ROTW   = 4
) (
    input logic [CONSTW+ROTW-1:0] op_field,
    input logic                   use_imm,
    input logic [XLEN-1:0]        rm_val,
    input logic [XLEN-1:0]        rs_val,
    input logic                   carry_in,
    input logic [XLEN-1:0]        operand_out,
    input logic                   carry_out
);
    logic [7:0] amt;
    logic [1:0] kind;
    logic [XLEN-1:0] kz;

    always_comb begin
        amt  = op_field[4] ? rs_val[7:0] : {3'b000, op_field[11:7]};
        kind = op_field[6:5];
        kz   = {{(XLEN-CONSTW){1'b0}}, op_field[CONSTW-1:0]};

        a_r1_bit_count: assert (!use_imm ||
            $countones(operand_out) == $countones(op_field[CONSTW-1:0]));

        a_r2_no_rotation: assert (!(use_imm && op_field[CONSTW+ROTW-1:CONSTW] == '0) ||
            (operand_out == kz && carry_out == carry_in));

        a_r3_imm_carry: assert (!(use_imm && op_field[CONSTW+ROTW-1:CONSTW] != '0) ||
            carry_out == operand_out[XLEN-1]);

        a_r9_zero_pass: assert (!(!use_imm && amt == 8'd0) ||
            (operand_out == rm_val && carry_out == carry_in));

        a_r10_logical_wide: assert (!(!use_imm && kind[1] == 1'b0 && amt >= 8'd32) ||
            operand_out == '0);

        a_r11_arith_wide: assert (!(!use_imm && kind == 2'd2 && amt >= 8'd32) ||
            (operand_out == {XLEN{rm_val[XLEN-1]}} && carry_out == rm_val[XLEN-1]));

        a_r7_rotate_carry: assert (!(!use_imm && kind == 2'd3 && amt != 8'd0) ||
            carry_out == operand_out[XLEN-1]);
    end
endmodule

bind opnd2_shifter opnd2_shifter_chk #(.XLEN(XLEN), .CONSTW(CONSTW), .ROTW(ROTW)) u_chk (
    .op_field    (op_field),
    .use_imm     (use_imm),
    .rm_val      (rm_val),
    .rs_val      (rs_val),
    .carry_in    (carry_in),
    .operand_out (operand_out),
    .carry_out   (carry_out)
);

// File: tb/sim_opnd2_shifter.sv
module sim_opnd2_shifter;
    logic        clk = 1'b0;
    logic [11:0] op_field;
    logic        use_imm;
    logic [31:0] rm_val, rs_val;
    logic        carry_in;
    logic [31:0] operand_out;
    logic        carry_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    opnd2_shifter u0 (
        .op_field    (op_field),
        .use_imm     (use_imm),
        .rm_val      (rm_val),
        .rs_val      (rs_val),
        .carry_in    (carry_in),
        .operand_out (operand_out),
        .carry_out   (carry_out)
    );

    function automatic logic [32:0] model(input logic imm, input logic [11:0] f,
                                          input logic [31:0] rm, input logic [31:0] rs,
                                          input logic cin);
        logic [31:0] res;
        logic        c;
        int          amt, r, m;
        logic [31:0] k;
        res = '0;
        c   = cin;
        if (imm) begin
            k = {24'd0, f[7:0]};
            r = 2 * int'(f[11:8]);
            for (int i = 0; i < 32; i++) res[i] = k[(i + r) % 32];
            c = (r == 0) ? cin : res[31];
        end else begin
            amt = f[4] ? int'(rs[7:0]) : int'(f[11:7]);
            if (amt == 0) begin
                res = rm;
                c   = cin;
            end else begin
                case (f[6:5])
                    2'd0: begin
                        for (int i = 0; i < 32; i++) res[i] = (i - amt >= 0) ? rm[i - amt] : 1'b0;
                        c = (amt <= 32) ? rm[32 - amt] : 1'b0;
                    end
                    2'd1: begin
                        for (int i = 0; i < 32; i++) res[i] = (i + amt < 32) ? rm[i + amt] : 1'b0;
                        c = (amt <= 32) ? rm[amt - 1] : 1'b0;
                    end
                    2'd2: begin
                        for (int i = 0; i < 32; i++) res[i] = (i + amt < 32) ? rm[i + amt] : rm[31];
                        c = (amt <= 32) ? rm[amt - 1] : rm[31];
                    end
                    default: begin
                        m = amt % 32;
                        for (int i = 0; i < 32; i++) res[i] = rm[(i + m) % 32];
                        c = res[31];
                    end
                endcase
            end
        end
        return {c, res};
    endfunction

    function automatic logic [11:0] regf(input logic [4:0] cnt, input logic [1:0] kind,
                                         input logic from_rs, input logic [3:0] idx);
        return {cnt, kind, from_rs, idx};
    endfunction

    task automatic check(input string tag, input logic [31:0] exp_v, input logic exp_c);
        n_checks++;
        if (operand_out !== exp_v || carry_out !== exp_c) begin
            n_fail++;
            $display("FAIL %s: got %h/%b expected %h/%b", tag, operand_out, carry_out, exp_v, exp_c);
        end
    endtask

    task automatic apply(input logic imm, input logic [11:0] f, input logic [31:0] rm,
                         input logic [31:0] rs, input logic cin);
        @(negedge clk);
        use_imm  = imm;
        op_field = f;
        rm_val   = rm;
        rs_val   = rs;
        carry_in = cin;
        #5;
    endtask

    task automatic run_model(input string tag);
        logic [32:0] e;
        e = model(use_imm, op_field, rm_val, rs_val, carry_in);
        check(tag, e[31:0], e[32]);
    endtask

    initial begin
        logic [31:0] prev;
        logic [31:0] x;
        logic        pc;
        int          seed;
        seed = 32'h5eed_0042;
        void'($urandom(seed));

        apply(1'b0, 12'h000, 32'h0, 32'h0, 1'b0);
        check("R9 idle zero", 32'h0, 1'b0);

        apply(1'b1, 12'h4FF, 32'h1234_5678, 32'h0, 1'b0);
        check("R1 const FF rot8", 32'hFF00_0000, 1'b1);
        apply(1'b1, 12'hF3C, 32'h0, 32'h0, 1'b0);
        check("R1 const 3C rot30", 32'h0000_00F0, 1'b0);
        apply(1'b1, 12'h0A5, 32'hFFFF_FFFF, 32'h0, 1'b1);
        check("R2 rot zero keeps carry", 32'h0000_00A5, 1'b1);
        apply(1'b1, 12'h101, 32'h0, 32'h0, 1'b0);
        check("R3 carry bit31", 32'h4000_0000, 1'b0);
        apply(1'b1, 12'h102, 32'h0, 32'h0, 1'b0);
        check("R3 carry bit31 set", 32'h8000_0000, 1'b1);

        x = 32'h8000_0001;
        apply(1'b0, regf(5'd4, 2'd0, 1'b0, 4'h0), 32'h8765_4321, 32'h0, 1'b0);
        check("R4 lsl 4", 32'h7654_3210, 1'b0);
        apply(1'b0, regf(5'd1, 2'd0, 1'b0, 4'h0), x, 32'h0, 1'b0);
        check("R4 lsl 1 carry", 32'h0000_0002, 1'b1);
        apply(1'b0, regf(5'd8, 2'd1, 1'b0, 4'h0), 32'h8765_4321, 32'h0, 1'b1);
        check("R5 lsr 8", 32'h0087_6543, 1'b0);
        apply(1'b0, regf(5'd7, 2'd2, 1'b0, 4'h0), 32'h8000_0040, 32'h0, 1'b0);
        check("R6 asr 7", 32'hFF00_0000, 1'b1);

        apply(1'b0, regf(5'd12, 2'd3, 1'b0, 4'h0), 32'h1234_5678, 32'h0, 1'b0);
        x = (32'h1234_5678 << 20) | (32'h1234_5678 >> 12);
        check("R7 ror12 equals rol20", x, x[31]);

        apply(1'b0, regf(5'd0, 2'd0, 1'b1, 4'hF), 32'h0000_00FF, 32'hABCD_EF03, 1'b0);
        check("R8 register amount low byte", 32'h0000_07F8, 1'b0);
        apply(1'b0, regf(5'd3, 2'd0, 1'b0, 4'h9), 32'h0000_00FF, 32'h0000_0000, 1'b0);
        check("R8 field count ignores index", 32'h0000_07F8, 1'b0);

        apply(1'b0, regf(5'd0, 2'd2, 1'b0, 4'h0), 32'h8000_0000, 32'h0, 1'b1);
        check("R9 zero amount asr", 32'h8000_0000, 1'b1);
        apply(1'b0, regf(5'd0, 2'd3, 1'b1, 4'h0), 32'hDEAD_BEEF, 32'h0000_0F00, 1'b0);
        check("R9 zero register amount", 32'hDEAD_BEEF, 1'b0);

        apply(1'b0, regf(5'd0, 2'd0, 1'b1, 4'h0), 32'h0000_0001, 32'd32, 1'b0);
        check("R10 lsl 32", 32'h0, 1'b1);
        apply(1'b0, regf(5'd0, 2'd1, 1'b1, 4'h0), 32'h8000_0000, 32'd32, 1'b0);
        check("R10 lsr 32", 32'h0, 1'b1);
        apply(1'b0, regf(5'd0, 2'd1, 1'b1, 4'h0), 32'hFFFF_FFFF, 32'd33, 1'b1);
        check("R10 lsr 33", 32'h0, 1'b0);
        apply(1'b0, regf(5'd0, 2'd0, 1'b1, 4'h0), 32'hFFFF_FFFF, 32'd200, 1'b1);
        check("R10 lsl 200", 32'h0, 1'b0);

        apply(1'b0, regf(5'd0, 2'd2, 1'b1, 4'h0), 32'h9000_0000, 32'd40, 1'b0);
        check("R11 asr 40 negative", 32'hFFFF_FFFF, 1'b1);
        apply(1'b0, regf(5'd0, 2'd2, 1'b1, 4'h0), 32'h7FFF_FFFF, 32'd255, 1'b1);
        check("R11 asr 255 positive", 32'h0, 1'b0);

        apply(1'b0, regf(5'd0, 2'd3, 1'b1, 4'h0), 32'h8000_1234, 32'd32, 1'b0);
        check("R12 ror 32", 32'h8000_1234, 1'b1);
        apply(1'b0, regf(5'd0, 2'd3, 1'b1, 4'h0), 32'h0000_0010, 32'd68, 1'b0);
        check("R12 ror 68", 32'h0000_0001, 1'b0);

        for (int i = 0; i < 3000; i++) begin
            apply(1'($urandom), 12'($urandom), $urandom, $urandom & 32'h0000_FF3F, 1'($urandom));
            run_model("R4 R5 R6 R7 random");
        end

        for (int i = 0; i < 200; i++) begin
            x  = $urandom;
            pc = 1'($urandom);
            apply(1'b0, regf(5'd0, 2'($urandom), 1'b1, 4'h0), x, {24'd0, 8'($urandom % 5)}, pc);
            prev = operand_out;
            apply(1'b0, op_field, x, {$urandom, rs_val[7:0]} & 32'hFFFF_FF00 | rs_val, pc);
            rs_val = {24'($urandom), rs_val[7:0]};
            #1;
            check("R8 upper rs ignored", prev, carry_out);
            run_model("R8 random upper");
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule